// File: doc/BRIEF.md
# Same-Address Collision Arbiter for a Two-Port Memory

This block sits between the two access ports of a dual-port memory and the memory array. Every cycle it compares the two ports. When both are enabled and present the same address, that is a collision, whatever the read/write direction of either port. The block then names one port the owner of the location. It pulls the other port's active-low busy line low and blocks that port's writes toward the array. The losing port's reads still go through. Busy stays low while the owner keeps accessing the location. It returns high in the same cycle that the owner leaves.

A mode input selects the block's role. When the mode input is high, the block arbitrates on its own and drives its busy outputs. When the mode input is low, arbitration is switched off and the busy outputs stay high. Write gating then follows two busy inputs, which an arbitrating device elsewhere in the system drives. Several devices can therefore share one arbitration result when they are placed side by side to widen the data path.

The owner is held in a register. The busy lines and the write gates are formed combinationally from that register and the port inputs, so a collision gates a write in the same cycle in which it appears.

Top module: `dp_collide_arb`

## Requirements
- R1: In arbitrating mode (`arb_mode`=1), when both ports are enabled at the same address, exactly one busy output is low. This holds even when both ports are reading.
- R2: In arbitrating mode, when no collision exists, both `l_busy_n` and `r_busy_n` are high.
- R3: If one port was enabled at an address in the previous cycle and the other port arrives at that address now, the port that was there first wins, and the newcomer's busy output goes low.
- R4: If neither port was already at the contested address, or both were, the left port wins and `r_busy_n` goes low.
- R5: Once a winner is recorded, the loser's busy stays low for as long as the collision lasts.
- R6: Busy returns high in the same cycle that the collision ends.
- R7: The qualified write `x_wr_go` equals `x_en & x_wr & effective_busy_n`. A busy port never writes.
- R8: The qualified read `x_rd_go` equals `x_en & ~x_wr`, whatever the busy state.
- R9: In following mode (`arb_mode`=0), both busy outputs are high, and each port's effective busy is taken from its `x_busy_in_n` input.
- R10: In following mode with both busy inputs high, colliding writes from both ports both go through.
- R11: While `rst_n` is low, both busy outputs are high. After reset, no winner is recorded, so a collision in the first cycle resolves as a tie.
- R12: In arbitrating mode the busy inputs are ignored. A low busy input blocks no write when there is no collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arb_mode | input | 1 | 1: arbitrate locally; 0: follow busy inputs |
| l_en | input | 1 | Left port enable |
| l_addr | input | ADDR_W | Left port address |
| l_wr | input | 1 | Left port write (1) or read (0) |
| r_en | input | 1 | Right port enable |
| r_addr | input | ADDR_W | Right port address |
| r_wr | input | 1 | Right port write (1) or read (0) |
| l_busy_in_n | input | 1 | External active-low busy for the left port, used in following mode |
| r_busy_in_n | input | 1 | External active-low busy for the right port, used in following mode |
| l_busy_n | output | 1 | Left port busy, active low |
| r_busy_n | output | 1 | Right port busy, active low |
| l_wr_go | output | 1 | Qualified left write toward the array |
| r_wr_go | output | 1 | Qualified right write toward the array |
| l_rd_go | output | 1 | Qualified left read toward the array |
| r_rd_go | output | 1 | Qualified right read toward the array |

## Verification
The bench builds the block with the default `ADDR_W` of 12. The arbitration depends only on whether two addresses are equal, not on the width, so small addresses such as 5, 9 and 20 cover every path. One scripted sequence moves through reset with a live collision, a first-cycle tie, both arrival orders, hold and release, read-only collisions, and following mode with the busy inputs high and low. That sequence reaches every transition of the recorded-owner state, including a switch between modes while an owner is recorded.

// File: rtl/dp_collide_arb_pkg.sv
package dp_collide_arb_pkg;

  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_L    = 2'd1,
    SIDE_R    = 2'd2
  } side_e;

  // Earlier arrival wins; ties (both new or both held) go to the left port.
  function automatic side_e pick_side(input logic l_held, input logic r_held);
    if (r_held && !l_held) return SIDE_R;
    return SIDE_L;
  endfunction

  // Qualified write: enabled write with busy released.
  function automatic logic write_pass(input logic en, input logic wr, input logic busy_n);
    return en & wr & busy_n;
  endfunction

  // Qualified read: never gated by busy.
  function automatic logic read_pass(input logic en, input logic wr);
    return en & ~wr;
  endfunction

endpackage

// File: rtl/dpa_track.sv
module dpa_track #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              held
);
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr;
    end
  end

  // Port was on this same location in the previous cycle.
  assign held = en && en_q && (addr == addr_q);
endmodule

// File: rtl/dpa_owner.sv
module dpa_owner
  import dp_collide_arb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  arb_mode,
  input  logic  collide,
  input  logic  l_held,
  input  logic  r_held,
  output side_e owner_now,
  output side_e owner_q
);
  always_comb begin
    if (!rst_n || !arb_mode || !collide) owner_now = SIDE_NONE;
    else if (owner_q != SIDE_NONE)       owner_now = owner_q;
    else                                 owner_now = pick_side(l_held, r_held);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owner_q <= SIDE_NONE;
    else        owner_q <= owner_now;
  end
endmodule

// File: rtl/dpa_gate.sv
module dpa_gate
  import dp_collide_arb_pkg::*;
(
  input  logic en,
  input  logic wr,
  input  logic busy_n,
  output logic wr_go,
  output logic rd_go
);
  assign wr_go = write_pass(en, wr, busy_n);
  assign rd_go = read_pass(en, wr);
endmodule

// File: rtl/dp_collide_arb.sv
module dp_collide_arb
  import dp_collide_arb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arb_mode,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_go,
  output logic              r_wr_go,
  output logic              l_rd_go,
  output logic              r_rd_go
);
  logic  collide;
  logic  l_held, r_held;
  side_e owner_now, owner_q;
  logic  arb_l_busy_n, arb_r_busy_n;
  logic  l_busy_eff_n, r_busy_eff_n;

  assign collide = l_en && r_en && (l_addr == r_addr);

  dpa_track #(.ADDR_W(ADDR_W)) u_trk_l (
    .clk(clk), .rst_n(rst_n), .en(l_en), .addr(l_addr), .held(l_held));
  dpa_track #(.ADDR_W(ADDR_W)) u_trk_r (
    .clk(clk), .rst_n(rst_n), .en(r_en), .addr(r_addr), .held(r_held));

  dpa_owner u_own (
    .clk(clk), .rst_n(rst_n), .arb_mode(arb_mode), .collide(collide),
    .l_held(l_held), .r_held(r_held), .owner_now(owner_now), .owner_q(owner_q));

  // Loser is the side not recorded as owner.
  assign arb_l_busy_n = (owner_now != SIDE_R);
  assign arb_r_busy_n = (owner_now != SIDE_L);

  assign l_busy_eff_n = arb_mode ? arb_l_busy_n : l_busy_in_n;
  assign r_busy_eff_n = arb_mode ? arb_r_busy_n : r_busy_in_n;

  assign l_busy_n = arb_mode ? arb_l_busy_n : 1'b1;
  assign r_busy_n = arb_mode ? arb_r_busy_n : 1'b1;

  dpa_gate u_gate_l (
    .en(l_en), .wr(l_wr), .busy_n(l_busy_eff_n), .wr_go(l_wr_go), .rd_go(l_rd_go));
  dpa_gate u_gate_r (
    .en(r_en), .wr(r_wr), .busy_n(r_busy_eff_n), .wr_go(r_wr_go), .rd_go(r_rd_go));
endmodule

// File: rtl/dp_collide_arb_chk.sv
module dp_collide_arb_chk
  import dp_collide_arb_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  arb_mode,
  input logic  l_en,
  input logic  l_wr,
  input logic  r_en,
  input logic  r_wr,
  input logic  collide,
  input logic  r_held,
  input side_e owner_q,
  input logic  l_busy_eff_n,
  input logic  r_busy_eff_n,
  input logic  l_busy_n,
  input logic  r_busy_n,
  input logic  l_wr_go,
  input logic  r_wr_go,
  input logic  l_rd_go,
  input logic  r_rd_go
);
  p_one_loser_r1: assert property (@(posedge clk) disable iff (!rst_n)
    arb_mode && collide |-> (l_busy_n ^ r_busy_n));

  p_idle_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arb_mode && !collide |-> (l_busy_n && r_busy_n));

  p_tie_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arb_mode && collide && owner_q == SIDE_NONE && !r_held |-> !r_busy_n);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arb_mode && collide && $past(arb_mode && collide && !r_busy_n) |-> !r_busy_n);

  p_gate_l_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !l_busy_eff_n |-> !l_wr_go);

  p_gate_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !r_busy_eff_n |-> !r_wr_go);

  p_read_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && !l_wr |-> l_rd_go) and (r_en && !r_wr |-> r_rd_go));

  p_follow_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_mode |-> (l_busy_n && r_busy_n));

  // R11: busy released throughout reset.
  always_comb begin
    if (!rst_n) a_reset_busy_r11: assert (l_busy_n && r_busy_n);
  end
endmodule

bind dp_collide_arb dp_collide_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arb_mode(arb_mode),
  .l_en(l_en), .l_wr(l_wr), .r_en(r_en), .r_wr(r_wr),
  .collide(collide), .r_held(r_held), .owner_q(owner_q),
  .l_busy_eff_n(l_busy_eff_n), .r_busy_eff_n(r_busy_eff_n),
  .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
  .l_wr_go(l_wr_go), .r_wr_go(r_wr_go),
  .l_rd_go(l_rd_go), .r_rd_go(r_rd_go));

// File: tb/dp_collide_arb_bench.sv
module dp_collide_arb_bench;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arb_mode = 1'b1;
  logic l_en = 1'b0, l_wr = 1'b0, r_en = 1'b0, r_wr = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
  logic l_busy_n, r_busy_n, l_wr_go, r_wr_go, l_rd_go, r_rd_go;

  always #5 clk = ~clk;

  dp_collide_arb #(.ADDR_W(AW)) u_dp_collide_arb (
    .clk(clk), .rst_n(rst_n), .arb_mode(arb_mode),
    .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr),
    .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .l_wr_go(l_wr_go), .r_wr_go(r_wr_go),
    .l_rd_go(l_rd_go), .r_rd_go(r_rd_go));

  typedef struct {
    string tag;
    logic [5:0] v; // {l_busy_n, r_busy_n, l_wr_go, r_wr_go, l_rd_go, r_rd_go}
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic step(input logic rst, input logic mode,
                      input logic le, input int la, input logic lw,
                      input logic re, input int ra, input logic rw,
                      input logic lbi, input logic rbi,
                      input logic elb, input logic erb,
                      input logic elw, input logic erw, input string tag);
    exp_t e;
    @(negedge clk);
    rst_n = rst; arb_mode = mode;
    l_en = le; l_addr = AW'(la); l_wr = lw;
    r_en = re; r_addr = AW'(ra); r_wr = rw;
    l_busy_in_n = lbi; r_busy_in_n = rbi;
    e.tag = tag;
    e.v = {elb, erb, elw, erw, le & ~lw, re & ~rw};
    q.push_back(e);
  endtask

  // Monitor: sample 4 ns after the drive edge, before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (q.size() > 0) begin
        exp_t e;
        logic [5:0] got;
        e = q.pop_front();
        got = {l_busy_n, r_busy_n, l_wr_go, r_wr_go, l_rd_go, r_rd_go};
        checks++;
        if (got !== e.v) begin
          errors++;
          $display("FAIL %s: got %b expected %b", e.tag, got, e.v);
        end
      end
    end
  end

  initial begin
    //    rst mode le la lw  re ra rw  lbi rbi  elb erb elw erw
    step(0, 1,  1, 5, 0,  1, 5, 0,  1, 1,  1, 1, 0, 0, "R11 busy high in reset");
    step(1, 1,  1, 5, 1,  1, 5, 1,  1, 1,  1, 0, 1, 0, "R4 R11 first-cycle tie to left");
    step(1, 1,  1, 5, 1,  1, 5, 1,  1, 1,  1, 0, 1, 0, "R5 busy held");
    step(1, 1,  0, 5, 0,  1, 5, 1,  1, 1,  1, 1, 0, 1, "R6 release when winner leaves");
    step(1, 1,  0, 0, 0,  0, 0, 0,  1, 1,  1, 1, 0, 0, "R2 idle");
    step(1, 1,  0, 0, 0,  1, 9, 1,  1, 1,  1, 1, 0, 1, "R2 right alone");
    step(1, 1,  1, 9, 1,  1, 9, 1,  1, 1,  0, 1, 0, 1, "R3 R7 earlier right wins");
    step(1, 1,  1, 9, 0,  1, 9, 1,  1, 1,  0, 1, 0, 1, "R8 loser read passes");
    step(1, 1,  1, 9, 0,  0, 9, 0,  1, 1,  1, 1, 0, 0, "R6 release on right exit");
    step(1, 1,  1, 3, 1,  1, 4, 1,  1, 1,  1, 1, 1, 1, "R2 distinct addresses");
    step(1, 1,  1, 3, 1,  1, 4, 1,  0, 0,  1, 1, 1, 1, "R12 inputs ignored");
    step(1, 1,  1, 7, 0,  1, 7, 0,  1, 1,  1, 0, 0, 0, "R1 read-only collision");
    step(1, 0,  1, 7, 1,  1, 7, 1,  1, 1,  1, 1, 1, 1, "R10 follow mode no inhibit");
    step(1, 0,  1, 1, 1,  1, 2, 1,  0, 1,  1, 1, 0, 1, "R9 left inhibited by input");
    step(1, 0,  1, 1, 1,  1, 2, 1,  1, 0,  1, 1, 1, 0, "R9 right inhibited by input");
    step(1, 1,  1, 20, 1, 0, 0, 0,  1, 1,  1, 1, 1, 0, "R2 left alone");
    step(1, 1,  1, 20, 1, 1, 20, 1, 1, 1,  1, 0, 1, 0, "R3 R7 earlier left wins");
    step(1, 1,  0, 0, 0,  0, 0, 0,  1, 1,  1, 1, 0, 0, "R6 both leave");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule